// File: doc/BRIEF.md
# First-Echo Timing Gate

This block sits between a free-running threshold comparator and a timing consumer in a pulse-echo ranging receiver. It takes the comparator's raw, asynchronous output and reduces it to at most one qualified timing event for each transmit burst. A one-cycle transmit-trigger pulse starts an elapsed-time counter. The counter defines three regions. First comes a blanking interval, in which transmit feedthrough and ringdown are ignored. Next comes an acceptance window set by a start time and an end time. The last region is a re-arm interval that follows an accepted event.

The comparator signal is brought into the clock domain through a synchronizer. Rising edges are detected on the synchronized level. A rising edge can start a candidate only if it begins inside the window and after blanking. The candidate becomes an event once the level has stayed high for the qualification length. When an event is accepted, the block issues a one-cycle pulse, raises a valid flag and latches a timestamp. The timestamp is corrected for synchronizer latency, so it names the clock edge that first captured the comparator high, counted from the edge that captured the trigger. Rising edges after blanking but outside the window set a sticky flag. A trigger that arrives during re-arm is reported as an overrun and is otherwise dropped.

Top module: `echo_gate`

## Requirements
- R1: A rising edge whose start time e (edges from the edge that captured `txTrig` to the edge that first captured `cmpIn` high) is below `blankLen` never produces an event, whatever its length.
- R2: A qualified event requires `winStart <= e < winEnd` and `e >= blankLen`. `stampOut` then holds e and `validOut` is 1.
- R3: In one burst, only the first qualifying rising edge is accepted. `evtOut` is high for exactly one cycle, and later crossings in the same burst change neither `stampOut` nor `validOut`. Each burst gives zero or one event.
- R4: After an event pulse, a trigger during the next `rearmLen` cycles is rejected. Such a trigger pulses `overrunOut` for one cycle, does not restart the counter and does not clear `validOut` or `stampOut`. The first trigger after that interval is accepted.
- R5: A candidate qualifies after Q consecutive high synchronized samples, where Q = max(`minWidth`, `stableLen`) and a value of 0 or 1 means a single sample. A shorter high is rejected, and a later rising edge in the window may still qualify. `evtOut` is high in the cycle after clock edge T+e+1+Q, where T is the trigger edge.
- R6: Only rising edges count. A level that is already high before the window, and stays high, never produces an event.
- R7: A rising edge with e >= `blankLen` that lies outside the window sets `outsideOut`. The flag stays set until the next accepted trigger.
- R8: If `winEnd <= winStart`, no event is ever accepted.
- R9: After reset, `evtOut`, `validOut`, `outsideOut`, `overrunOut` and `stampOut` are all 0.
- R10: A trigger that arrives while the block is not in re-arm restarts timing from that edge. It also clears `validOut`, `outsideOut` and any candidate in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txTrig | input | 1 | Transmit trigger, one-cycle pulse |
| cmpIn | input | 1 | Raw comparator output, asynchronous |
| blankLen | input | CNT_W | Blanking length in cycles |
| winStart | input | CNT_W | First accepted start time |
| winEnd | input | CNT_W | Window end, exclusive |
| rearmLen | input | CNT_W | Re-arm length in cycles after an event |
| minWidth | input | QUAL_W | Minimum pulse width in samples |
| stableLen | input | QUAL_W | Minimum stable time before latching |
| evtOut | output | 1 | One-cycle qualified event pulse |
| stampOut | output | CNT_W | Latched corrected timestamp |
| validOut | output | 1 | Event accepted in the current burst |
| outsideOut | output | 1 | Sticky out-of-window activity flag |
| overrunOut | output | 1 | One-cycle pulse for a trigger rejected during re-arm |

## Verification
The hardest situations to reach are the ones where several timing rules meet in a single clock edge. One is a trigger landing on the exact last re-arm cycle. Another is a candidate that drops one sample short of qualification and is followed at once by a second rising edge still inside the window. Directed bursts place these edges at chosen cycles by writing a per-burst waveform indexed by elapsed time. A randomized phase then varies the blanking, window, qualification and re-arm settings, uses random gaps between bursts (so triggers fall inside re-arm), and drives random comparator runs. A behavioural reference model in the bench works from the history of raw samples and checks every output on every clock.

// File: rtl/echo_gate_pkg.sv
package echo_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_REARM = 2'd2
  } gateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;    // restart elapsed-time counter
    logic candStart;   // capture start time of a new candidate
    logic stampLoad;   // publish the candidate start time
    logic rearmClear;  // restart the re-arm counter
  } gateStrobe_t;
endpackage

// File: rtl/echo_gate_dp.sv
module echo_gate_dp
  import echo_gate_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int QUAL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpIn,
  input  gateStrobe_t       strobe,
  input  logic [CNT_W-1:0]  blankLen,
  input  logic [CNT_W-1:0]  winStart,
  input  logic [CNT_W-1:0]  winEnd,
  output logic              riseSeen,
  output logic              levelHigh,
  output logic              elapsedOk,
  output logic              inBlank,
  output logic              inWindow,
  output logic [QUAL_W:0]   runNext,
  output logic [CNT_W-1:0]  rearmCnt,
  output logic [CNT_W-1:0]  stampOut
);
  // latency from raw sample to synchronized level, in counter steps
  localparam int LAT = SYNC_STAGES - 1;
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLevel;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       elapsed;
  logic [QUAL_W-1:0]      runLen;
  logic [CNT_W-1:0]       candStamp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      prevLevel <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_STAGES-2:0], cmpIn};
      prevLevel <= syncQ[SYNC_STAGES-1];
    end
  end

  assign levelHigh = syncQ[SYNC_STAGES-1];
  assign riseSeen  = levelHigh && !prevLevel;

  // elapsed-time counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (cnt != '1)       cnt <= cnt + 1'b1;
  end

  // corrected start time of the raw edge now seen at the synchronizer output
  assign elapsed   = cnt - LAT_C;
  assign elapsedOk = (cnt >= LAT_C);
  assign inBlank   = (elapsed < blankLen);
  assign inWindow  = (elapsed >= winStart) && (elapsed < winEnd);

  // run length of the current candidate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              runLen <= '0;
    else if (strobe.candStart)              runLen <= QUAL_W'(1);
    else if (levelHigh && (runLen != '1))   runLen <= runLen + 1'b1;
  end
  assign runNext = {1'b0, runLen} + {{QUAL_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candStamp <= '0;
      stampOut  <= '0;
    end else begin
      if (strobe.candStart) candStamp <= elapsed;
      if (strobe.stampLoad) stampOut  <= strobe.candStart ? elapsed : candStamp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rearmCnt <= '0;
    else if (strobe.rearmClear) rearmCnt <= '0;
    else if (rearmCnt != '1)    rearmCnt <= rearmCnt + 1'b1;
  end
endmodule

// File: rtl/echo_gate_ctrl.sv
module echo_gate_ctrl
  import echo_gate_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int QUAL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txTrig,
  input  logic              riseSeen,
  input  logic              levelHigh,
  input  logic              elapsedOk,
  input  logic              inBlank,
  input  logic              inWindow,
  input  logic [QUAL_W:0]   runNext,
  input  logic [CNT_W-1:0]  rearmCnt,
  input  logic [CNT_W-1:0]  rearmLen,
  input  logic [QUAL_W-1:0] minWidth,
  input  logic [QUAL_W-1:0] stableLen,
  output gateStrobe_t       strobe,
  output logic              evtPulse,
  output logic              validFlag,
  output logic              outsideFlag,
  output logic              overrunPulse
);
  gateState_t        state;
  logic              candValid;
  logic [QUAL_W-1:0] qualNeed;
  logic              trigAccept, watching, riseLive, startCand, markOutside, hitNow;
  logic [CNT_W:0]    rearmNext;

  assign qualNeed    = (minWidth > stableLen) ? minWidth : stableLen;
  assign trigAccept  = txTrig && (state != ST_REARM);
  assign watching    = (state == ST_RUN) && !txTrig && elapsedOk;
  assign riseLive    = watching && riseSeen && !inBlank;
  assign startCand   = riseLive && inWindow;
  assign markOutside = riseLive && !inWindow;
  assign hitNow      = (startCand && (qualNeed <= QUAL_W'(1))) ||
                       (watching && candValid && levelHigh &&
                        (runNext >= {1'b0, qualNeed}));
  assign rearmNext   = {1'b0, rearmCnt} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    strobe            = '0;
    strobe.cntClear   = trigAccept;
    strobe.candStart  = startCand;
    strobe.stampLoad  = hitNow;
    strobe.rearmClear = hitNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (trigAccept) begin
      state <= ST_RUN;
    end else begin
      case (state)
        ST_RUN:   if (hitNow) state <= (rearmLen == '0) ? ST_IDLE : ST_REARM;
        ST_REARM: if (rearmNext >= {1'b0, rearmLen}) state <= ST_IDLE;
        default:  state <= state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candValid    <= 1'b0;
      evtPulse     <= 1'b0;
      validFlag    <= 1'b0;
      outsideFlag  <= 1'b0;
      overrunPulse <= 1'b0;
    end else begin
      evtPulse     <= hitNow;
      overrunPulse <= txTrig && (state == ST_REARM);
      if (trigAccept)      candValid <= 1'b0;
      else if (hitNow)     candValid <= 1'b0;
      else if (startCand)  candValid <= 1'b1;
      else if (!levelHigh) candValid <= 1'b0;
      if (trigAccept)  validFlag <= 1'b0;
      else if (hitNow) validFlag <= 1'b1;
      if (trigAccept)       outsideFlag <= 1'b0;
      else if (markOutside) outsideFlag <= 1'b1;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);  // R3
  AST_ONE_PER_BURST: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> !$past(validFlag));  // R3
  AST_REARM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REARM) |=> !evtPulse);  // R4
  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REARM && txTrig) |=> (overrunPulse && state != ST_RUN));  // R4
endmodule

// File: rtl/echo_gate.sv
module echo_gate
  import echo_gate_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int QUAL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txTrig,
  input  logic              cmpIn,
  input  logic [CNT_W-1:0]  blankLen,
  input  logic [CNT_W-1:0]  winStart,
  input  logic [CNT_W-1:0]  winEnd,
  input  logic [CNT_W-1:0]  rearmLen,
  input  logic [QUAL_W-1:0] minWidth,
  input  logic [QUAL_W-1:0] stableLen,
  output logic              evtOut,
  output logic [CNT_W-1:0]  stampOut,
  output logic              validOut,
  output logic              outsideOut,
  output logic              overrunOut
);
  gateStrobe_t      strobe;
  logic             riseSeen, levelHigh, elapsedOk, inBlank, inWindow;
  logic [QUAL_W:0]  runNext;
  logic [CNT_W-1:0] rearmCnt;

  echo_gate_dp #(.CNT_W(CNT_W), .QUAL_W(QUAL_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .strobe(strobe),
    .blankLen(blankLen), .winStart(winStart), .winEnd(winEnd),
    .riseSeen(riseSeen), .levelHigh(levelHigh), .elapsedOk(elapsedOk),
    .inBlank(inBlank), .inWindow(inWindow), .runNext(runNext),
    .rearmCnt(rearmCnt), .stampOut(stampOut)
  );

  echo_gate_ctrl #(.CNT_W(CNT_W), .QUAL_W(QUAL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .txTrig(txTrig),
    .riseSeen(riseSeen), .levelHigh(levelHigh), .elapsedOk(elapsedOk),
    .inBlank(inBlank), .inWindow(inWindow), .runNext(runNext),
    .rearmCnt(rearmCnt), .rearmLen(rearmLen),
    .minWidth(minWidth), .stableLen(stableLen),
    .strobe(strobe), .evtPulse(evtOut), .validFlag(validOut),
    .outsideFlag(outsideOut), .overrunPulse(overrunOut)
  );

  // timing inputs are held steady around a burst
  AST_EVT_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    evtOut |-> (stampOut >= blankLen));  // R1
  AST_EVT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    evtOut |-> (stampOut >= winStart && stampOut < winEnd));  // R2
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (winEnd <= winStart) |-> !evtOut);  // R8
endmodule

// File: tb/test_echo_gate.sv
`timescale 1ns/1ps
module test_echo_gate;
  localparam int CNT_W  = 16;
  localparam int QUAL_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0;
  logic cmp = 1'b0;
  int   cfgBlank = 10, cfgWs = 20, cfgWe = 60, cfgRearm = 30, cfgMinW = 0, cfgStab = 0;

  logic             evtOut, validOut, outsideOut, overrunOut;
  logic [CNT_W-1:0] stampOut;

  always #2 clk = ~clk;

  echo_gate #(.CNT_W(CNT_W), .QUAL_W(QUAL_W)) i_echo_gate (
    .clk(clk), .rstN(rstN), .txTrig(trig), .cmpIn(cmp),
    .blankLen(CNT_W'(cfgBlank)), .winStart(CNT_W'(cfgWs)), .winEnd(CNT_W'(cfgWe)),
    .rearmLen(CNT_W'(cfgRearm)), .minWidth(QUAL_W'(cfgMinW)), .stableLen(QUAL_W'(cfgStab)),
    .evtOut(evtOut), .stampOut(stampOut), .validOut(validOut),
    .outsideOut(outsideOut), .overrunOut(overrunOut)
  );

  int    compared = 0, mismatched = 0;
  string curReq = "R9";
  bit    wave [0:255];
  int    evtSeen = 0, overrunSeen = 0;
  bit    finished = 0;

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hist [$];
  int mState = 0;   // 0 idle, 1 watching, 2 re-arm
  int lastT = 0, rearmEnd = 0;
  bit expEvt = 0, expValid = 0, expOutside = 0, expOverrun = 0;
  int expStamp = 0;

  function automatic bit allHigh(int from, int len);
    for (int i = from; i < from + len; i++) if (!hist[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit inWin(int e);
    return (e >= cfgWs) && (e < cfgWe);
  endfunction

  always @(posedge clk) begin
    int q, e, n;
    if (!rstN) begin
      hist.push_back(1'b0);
      mState = 0; expEvt = 0; expValid = 0; expOutside = 0; expOverrun = 0; expStamp = 0;
    end else begin
      hist.push_back(cmp);
      n = hist.size() - 1;
      expEvt = 0; expOverrun = 0;
      q = (cfgMinW > cfgStab) ? cfgMinW : cfgStab;
      if (q < 1) q = 1;
      if (mState == 2) begin
        if (trig) expOverrun = 1;
        if (n >= rearmEnd) mState = 0;
      end else if (trig) begin
        mState = 1; lastT = n; expValid = 0; expOutside = 0;
      end else if (mState == 1) begin
        e = n - 1 - q - lastT;
        if (e >= 0 && e >= cfgBlank && inWin(e) && !hist[lastT+e-1] && allHigh(lastT+e, q)) begin
          expEvt = 1; expValid = 1; expStamp = e;
          rearmEnd = n + cfgRearm;
          mState = (cfgRearm == 0) ? 0 : 2;
        end else begin
          e = n - 2 - lastT;
          if (e >= 0 && e >= cfgBlank && !inWin(e) && hist[n-2] && !hist[n-3]) expOutside = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(curReq, "evtOut", int'(evtOut), int'(expEvt));
      check(curReq, "validOut", int'(validOut), int'(expValid));
      check(curReq, "outsideOut", int'(outsideOut), int'(expOutside));
      check(curReq, "overrunOut", int'(overrunOut), int'(expOverrun));
      check(curReq, "stampOut", int'(stampOut), expStamp);
      if (evtOut) evtSeen++;
      if (overrunOut) overrunSeen++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clearWave();
    for (int i = 0; i < 256; i++) wave[i] = 1'b0;
  endtask

  task automatic setHigh(int a, int b);
    for (int i = a; i < b; i++) wave[i] = 1'b1;
  endtask

  task automatic runBurst(int len);
    evtSeen = 0; overrunSeen = 0;
    for (int i = 0; i < len; i++) begin
      trig = (i == 0);
      cmp  = wave[i];
      @(posedge clk); #1;
    end
    trig = 1'b0; cmp = 1'b0;
  endtask

  task automatic idle(int n, bit lvl);
    for (int i = 0; i < n; i++) begin
      trig = 1'b0; cmp = lvl;
      @(posedge clk); #1;
    end
  endtask

  task automatic setCfg(int b, int ws, int we, int ra, int mw, int st);
    cfgBlank = b; cfgWs = ws; cfgWe = we; cfgRearm = ra; cfgMinW = mw; cfgStab = st;
  endtask

  initial begin
    #(4 * 100000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R9: reset state
    curReq = "R9";
    repeat (3) @(posedge clk);
    #1;
    check("R9", "evtOut in reset", int'(evtOut), 0);
    check("R9", "validOut in reset", int'(validOut), 0);
    check("R9", "stampOut in reset", int'(stampOut), 0);
    rstN = 1'b1;
    idle(6, 1'b0);

    // R2: single clean echo
    curReq = "R2";
    clearWave(); setHigh(30, 35);
    runBurst(80);
    check("R2", "stamp", int'(stampOut), 30);
    check("R2", "valid", int'(validOut), 1);
    check("R3", "events in burst", evtSeen, 1);

    // R10: retrigger before any event restarts timing and clears valid
    curReq = "R10";
    clearWave();
    runBurst(15);
    check("R10", "valid cleared by trigger", int'(validOut), 0);
    clearWave(); setHigh(24, 28);
    runBurst(80);
    check("R10", "stamp relative to new trigger", int'(stampOut), 24);

    // R1 and R7: ringdown in blanking, stray edge before window, then echo
    curReq = "R1";
    clearWave(); setHigh(1, 4); setHigh(7, 9); setHigh(12, 14); setHigh(25, 27);
    runBurst(80);
    check("R1", "stamp skips blanked activity", int'(stampOut), 25);
    check("R7", "outside flag after pre-window edge", int'(outsideOut), 1);

    // R3 and R6: chatter inside window
    curReq = "R3";
    clearWave(); setHigh(25, 27); setHigh(28, 29); setHigh(30, 32); setHigh(50, 53);
    runBurst(80);
    check("R3", "first crossing kept", int'(stampOut), 25);
    check("R3", "one event despite chatter", evtSeen, 1);

    // R5: minimum width
    curReq = "R5";
    setCfg(10, 20, 60, 30, 4, 0);
    clearWave(); setHigh(22, 24); setHigh(30, 36);
    runBurst(80);
    check("R5", "short high rejected, later qualifies", int'(stampOut), 30);
    // R5: stable time dominates width
    setCfg(10, 20, 60, 30, 2, 5);
    clearWave(); setHigh(22, 26); setHigh(33, 41);
    runBurst(80);
    check("R5", "stable time qualification", int'(stampOut), 33);
    check("R5", "one event", evtSeen, 1);

    // R4: trigger during re-arm is an overrun
    curReq = "R4";
    setCfg(10, 20, 60, 30, 0, 0);
    clearWave(); setHigh(25, 26);
    runBurst(40);
    clearWave(); setHigh(10, 12);
    runBurst(40);
    check("R4", "overrun seen", overrunSeen, 1);
    check("R4", "valid kept", int'(validOut), 1);
    check("R4", "stamp kept", int'(stampOut), 25);
    clearWave(); setHigh(40, 42);
    runBurst(80);
    check("R4", "trigger after re-arm accepted", int'(stampOut), 40);

    // R8: empty window
    curReq = "R8";
    setCfg(10, 30, 30, 30, 0, 0);
    clearWave(); setHigh(32, 35);
    runBurst(80);
    check("R8", "no event", evtSeen, 0);
    check("R8", "no valid", int'(validOut), 0);
    check("R7", "edge flagged outside", int'(outsideOut), 1);

    // R6: level already high through the window
    curReq = "R6";
    setCfg(10, 20, 60, 30, 0, 0);
    idle(5, 1'b1);
    clearWave(); setHigh(0, 80);
    runBurst(80);
    check("R6", "no event without rising edge", evtSeen, 0);
    idle(5, 1'b0);

    // randomized bursts, all rules against the model
    curReq = "R3";
    for (int b = 0; b < 60; b++) begin
      int bl, ws, we;
      bl = $urandom_range(0, 15);
      ws = $urandom_range(0, 30);
      we = ws + $urandom_range(0, 30) - 3;
      if (we < 0) we = 0;
      setCfg(bl, ws, we, $urandom_range(0, 40), $urandom_range(0, 4), $urandom_range(0, 4));
      clearWave();
      for (int r = 0; r < 8; r++) begin
        int st;
        st = $urandom_range(0, 70);
        setHigh(st, st + $urandom_range(1, 5));
      end
      runBurst(80);
      check("R3", "at most one event per burst", (evtSeen <= 1) ? 1 : 0, 1);
      idle($urandom_range(0, 30), 1'b0);
    end

    idle(10, 1'b0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule